// File: doc/BRIEF.md
# Receive Sync-to-Async Rate Converter

This block sits on the receive side of a modem, after the descrambler. It takes the synchronous bit stream, one bit per bit-clock enable, and finds the character framing in it: a start bit (0), a fixed number of data bits and a stop bit (1). It then sends each character out again on an asynchronous line. The output is timed by an oversampling tick at 16 ticks per bit.

A far-end transmitter whose source runs slightly fast drops a stop bit now and then to keep up. When a start bit arrives in the slot where a stop bit belongs, this block counts that stop as deleted. It puts the stop back as a shortened interval, so the output can run slightly faster than the line. Two overspeed ranges can be selected, and each one sets how short the re-inserted stop is. A small slot FIFO between the framing logic and the output serializer absorbs the time slip that the re-inserted stops cause. In FSK mode, or in synchronous mode, the block is bypassed: the input bit drives the output directly, and the framing state is cleared.

Top module: `s2a_sync_async`

## Requirements
- R1: After reset, and whenever no character is being sent, `async_out` is 1 (mark). Mark bits received outside a character produce no output.
- R2: `char_len` selects the total character length, counting start and stop: 0→8, 1→9, 2→10, 3→11 bits. The data bits go out in the order they arrived, which is LSB first. Each character is framed by a 0 start bit and a 1 stop bit.
- R3: Start bits, data bits and stop bits that were not deleted each last exactly 16 ticks of `tick_en`.
- R4: A 0 sampled in the stop slot marks that stop bit as deleted. The 0 is taken as the start bit of the next character, and a stop interval is inserted on the output before that character.
- R5: When `ext_ovs`=1 (wider range), an inserted stop lasts 14 ticks.
- R6: When `ext_ovs`=0 (narrower range), an inserted stop lasts 15 ticks.
- R7: With `fsk_mode`=1, `async_out` equals `bit_in` in the same cycle, whatever the value of `sync_mode`.
- R8: With `sync_mode`=1, `async_out` equals `bit_in` in the same cycle.
- R9: While bypassed, all partially received framing state is discarded. After the bypass ends, no stale character is sent.
- R10: When stops are deleted on every character of a burst of up to 8 characters, or at most once every 4 characters in longer bursts, no slot is lost. Every character sent is output and decoded.
- R11: The output line changes only on a clock edge where `tick_en` is high. If ticks come every other clock, every bit stretches by the same factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Output timebase tick, 16 per bit |
| bit_en | input | 1 | Bit-clock enable: `bit_in` is valid on this cycle |
| bit_in | input | 1 | Descrambled synchronous bit |
| char_len | input | 2 | Character length select (8 to 11 bits in total) |
| ext_ovs | input | 1 | 1 selects the wider overspeed range (14-tick inserted stop) |
| fsk_mode | input | 1 | FSK mode: bypass, and `sync_mode` is ignored |
| sync_mode | input | 1 | Synchronous mode: bypass |
| async_out | output | 1 | Asynchronous serial output |

## Verification
Bursts of random characters run through every character length in both overspeed ranges. Stops are deleted at the highest rate each range allows, and one burst deletes a stop on every character. Decoding the data bits shows that the framing follows the length select. Measuring the high interval after each character shows 16 ticks for a kept stop and 14 or 15 ticks for an inserted one, which tells the two ranges apart. One burst runs with a tick on every other clock, which shows that all timing follows the tick and not the clock. Random bits driven in FSK, synchronous and combined modes check the pass-through path. A character abandoned partway through by a switch to bypass shows that no stale state survives.

// File: rtl/s2a_pkg.sv
// Shared types and constants for the receive sync-to-async converter.
// Assumes a 16x oversampled output timebase unless a parameter overrides it.
package s2a_pkg;
    localparam int TICKS_PER_BIT = 16;
    localparam int BASE_DATA_BITS = 6;   // data bits when char_len = 0
    localparam int CNT_W = 4;            // holds up to 9 data bits

    // Framing state of the receive deframer
    typedef enum logic [1:0] {
        DF_IDLE,
        DF_DATA,
        DF_STOP
    } df_state_t;

    // One output slot: bit value, end-of-frame marker, shortened-stop marker
    typedef struct packed {
        logic val;
        logic last;
        logic shrt;
    } slot_t;

    // Number of data bits for a character length select
    function automatic logic [CNT_W-1:0] data_bits(input logic [1:0] sel);
        return CNT_W'(BASE_DATA_BITS) + {{(CNT_W-2){1'b0}}, sel};
    endfunction
endpackage

// File: rtl/s2a_deframer.sv
// Receive deframer: finds start, data and stop slots in the synchronous
// stream and emits one output slot per received bit. A 0 in a stop slot is
// taken as a deleted stop: a shortened stop slot is emitted at once and the
// start slot of the next character one cycle later.
// Assumes bit_en is never high on two consecutive cycles.
module s2a_deframer
    import s2a_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic [1:0] char_len,
    output logic       push,
    output slot_t      push_slot
);
    df_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       len_q;
    logic             pend_start;
    logic [CNT_W-1:0] ndata;

    assign ndata = data_bits(len_q);

    // Slot emission for the current cycle
    always_comb begin
        push      = 1'b0;
        push_slot = '{val: 1'b1, last: 1'b0, shrt: 1'b0};
        if (pend_start) begin
            push      = 1'b1;
            push_slot = '{val: 1'b0, last: 1'b0, shrt: 1'b0};
        end else if (bit_en) begin
            unique case (state)
                DF_IDLE: begin
                    push      = !bit_in;
                    push_slot = '{val: 1'b0, last: 1'b0, shrt: 1'b0};
                end
                DF_DATA: begin
                    push      = 1'b1;
                    push_slot = '{val: bit_in, last: 1'b0, shrt: 1'b0};
                end
                DF_STOP: begin
                    push      = 1'b1;
                    push_slot = '{val: 1'b1, last: 1'b1, shrt: !bit_in};
                end
                default: push = 1'b0;
            endcase
        end
    end

    // Framing state machine and data-bit counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state      <= DF_IDLE;
            cnt        <= '0;
            len_q      <= 2'd0;
            pend_start <= 1'b0;
        end else begin
            pend_start <= 1'b0;
            if (bit_en) begin
                unique case (state)
                    DF_IDLE: begin
                        if (!bit_in) begin
                            state <= DF_DATA;
                            cnt   <= '0;
                            len_q <= char_len;
                        end
                    end
                    DF_DATA: begin
                        if (cnt == ndata - 1'b1) begin
                            state <= DF_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    DF_STOP: begin
                        if (bit_in) begin
                            state <= DF_IDLE;
                        end else begin
                            state      <= DF_DATA;
                            cnt        <= '0;
                            len_q      <= char_len;
                            pend_start <= 1'b1;
                        end
                    end
                    default: state <= DF_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/s2a_slot_fifo.sv
// Slot FIFO between deframer and serializer. It also counts the frames whose
// end-of-frame slot is stored, so the serializer can start a character only
// once all of it is buffered. A push when full is dropped.
module s2a_slot_fifo
    import s2a_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  slot_t                      din,
    input  logic                       pop,
    output slot_t                      dout,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       frame_ready
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    slot_t         mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] frames;
    logic          do_push, do_pop;

    assign empty       = (count == '0);
    assign do_pop      = pop && !empty;
    assign do_push     = push && ((count != CW'(DEPTH)) || do_pop);
    assign dout        = mem[rd_ptr];
    assign frame_ready = (frames != '0);

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointers, occupancy and frame count
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            frames <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            count  <= count + CW'(do_push) - CW'(do_pop);
            frames <= frames + CW'(do_push && din.last) - CW'(do_pop && dout.last);
        end
    end
endmodule

// File: rtl/s2a_serializer.sv
// Output serializer: sends slots on the oversampled timebase. A normal slot
// lasts TICKS ticks. A shortened stop lasts 7/8 of that in the wide range
// and 15/16 in the narrow range. A character starts only when a complete
// frame is buffered, so it never runs dry mid-character. The line idles at 1.
module s2a_serializer
    import s2a_pkg::*;
#(
    parameter int TICKS = TICKS_PER_BIT
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  tick_en,
    input  logic  ext_ovs,
    input  logic  frame_ready,
    input  logic  empty,
    input  slot_t head,
    output logic  pop,
    output logic  active,
    output logic  line
);
    localparam int TW = $clog2(TICKS);
    localparam logic [TW-1:0] FULL_M1 = TW'(TICKS - 1);
    localparam logic [TW-1:0] EXT_M1  = TW'(TICKS * 7 / 8 - 1);
    localparam logic [TW-1:0] STD_M1  = TW'(TICKS - TICKS / 16 - 1);

    logic [TW-1:0] tcnt, wid_m1;
    logic          cur_val, cur_last;
    logic          boundary;

    assign boundary = active && tick_en && (tcnt == wid_m1);
    assign line     = active ? cur_val : 1'b1;

    // Decide when the next slot is taken from the FIFO
    always_comb begin
        pop = 1'b0;
        if (tick_en && !empty) begin
            if (!active) begin
                pop = frame_ready;
            end else if (boundary) begin
                pop = cur_last ? frame_ready : 1'b1;
            end
        end
    end

    // Current slot, its width and the tick counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            active   <= 1'b0;
            tcnt     <= '0;
            wid_m1   <= FULL_M1;
            cur_val  <= 1'b1;
            cur_last <= 1'b0;
        end else if (pop) begin
            active   <= 1'b1;
            tcnt     <= '0;
            cur_val  <= head.val;
            cur_last <= head.last;
            wid_m1   <= head.shrt ? (ext_ovs ? EXT_M1 : STD_M1) : FULL_M1;
        end else if (boundary) begin
            active <= 1'b0;
        end else if (active && tick_en) begin
            tcnt <= tcnt + 1'b1;
        end
    end
endmodule

// File: rtl/s2a_sync_async.sv
// Top of the receive sync-to-async converter: deframer, slot FIFO and
// serializer. FSK or synchronous mode bypasses the path combinationally and
// holds the converter cleared. Assumes bit_en pulses are at least two cycles
// apart, and that the tick rate keeps up with the bit rate.
module s2a_sync_async
    import s2a_pkg::*;
#(
    parameter int TICKS      = TICKS_PER_BIT,
    parameter int FIFO_DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic [1:0] char_len,
    input  logic       ext_ovs,
    input  logic       fsk_mode,
    input  logic       sync_mode,
    output logic       async_out
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic          bypass;
    logic          df_push;
    slot_t         df_slot;
    slot_t         fifo_head;
    logic          fifo_empty;
    logic [CW-1:0] fifo_count;
    logic          fifo_frame_ready;
    logic          ser_pop;
    logic          ser_active;
    logic          ser_line;

    // FSK wins over the sync flag; either one bypasses
    assign bypass    = fsk_mode | sync_mode;
    assign async_out = bypass ? bit_in : ser_line;

    s2a_deframer deframer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (bypass),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .char_len  (char_len),
        .push      (df_push),
        .push_slot (df_slot)
    );

    s2a_slot_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (bypass),
        .push        (df_push),
        .din         (df_slot),
        .pop         (ser_pop),
        .dout        (fifo_head),
        .empty       (fifo_empty),
        .count       (fifo_count),
        .frame_ready (fifo_frame_ready)
    );

    s2a_serializer #(.TICKS(TICKS)) ser_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (bypass),
        .tick_en     (tick_en),
        .ext_ovs     (ext_ovs),
        .frame_ready (fifo_frame_ready),
        .empty       (fifo_empty),
        .head        (fifo_head),
        .pop         (ser_pop),
        .active      (ser_active),
        .line        (ser_line)
    );
endmodule

// File: rtl/s2a_checker.sv
// Property checker for the converter, bound to the top module.
module s2a_checker
    import s2a_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tick_en,
    input logic                       fsk_mode,
    input logic                       sync_mode,
    input logic                       async_out,
    input logic                       push,
    input slot_t                      push_slot,
    input logic                       pop,
    input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
    input logic                       ser_active
);
    // R1
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsk_mode && !sync_mode && !ser_active) |-> async_out);

    // R4
    reinsert_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_slot.shrt) |=> (push && !push_slot.val && !push_slot.last));

    // R9
    bypass_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsk_mode || sync_mode) |=> (fifo_cnt == '0));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (fifo_cnt < ($clog2(DEPTH+1))'(DEPTH)));

    // R11
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !fsk_mode && !sync_mode) |=>
            (fsk_mode || sync_mode || $stable(async_out)));
endmodule

bind s2a_sync_async s2a_checker #(.DEPTH(FIFO_DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .fsk_mode   (fsk_mode),
    .sync_mode  (sync_mode),
    .async_out  (async_out),
    .push       (df_push),
    .push_slot  (df_slot),
    .pop        (ser_pop),
    .fifo_cnt   (fifo_count),
    .ser_active (ser_active)
);

// File: tb/s2a_sync_async_tb_top.sv
`timescale 1ns/1ps
module s2a_sync_async_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, bit_en = 1'b0, bit_in = 1'b1;
    logic [1:0] char_len = 2'd0;
    logic       ext_ovs = 1'b0, fsk_mode = 1'b0, sync_mode = 1'b0;
    logic       async_out;

    always #2 clk = ~clk;   // 250 MHz

    s2a_sync_async dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bit_en(bit_en),
        .bit_in(bit_in), .char_len(char_len), .ext_ovs(ext_ovs),
        .fsk_mode(fsk_mode), .sync_mode(sync_mode), .async_out(async_out)
    );

    int n_chk = 0, n_fail = 0;
    int td = 1;                        // clocks per tick
    int cyc = 0;
    bit q [0:1023];
    int qrd = 0, qwr = 0;
    bit byp_drive = 0, byp_chk = 0, mon_en = 0;
    int exp_data [0:63];
    bit exp_del [0:63];
    int ecount = 0, ridx = 0;
    int ms = 0, k = 0, nd_cur = 6;
    bit ext_cur = 0;
    logic [15:0] rxv;

    function automatic int short_w(bit e);
        return e ? 14 : 15;
    endfunction

    function automatic int ndata(int s);
        return 6 + s;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Compare one decoded character with the expected one
    task automatic finish_char(int w);
        int d;
        d = 16 * td;
        if (ridx >= ecount) begin
            check(0, "R9 unexpected char", ridx, ecount);
        end else begin
            check(rxv == exp_data[ridx][15:0], "R2 data", rxv, exp_data[ridx]);
            if (exp_del[ridx])
                check(w == short_w(ext_cur) * td, ext_cur ? "R4 R5 stop" : "R4 R6 stop",
                      w / td, short_w(ext_cur));
            else
                check(w >= d, "R3 stop", w / td, 16);
            ridx++;
        end
    endtask

    // Input driver: paces ticks and bits, or drives random bits in bypass
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            if (byp_drive) begin
                bit_in  = 1'($urandom % 2);
                bit_en  = 1'($urandom % 2);
                tick_en = 1'($urandom % 2);
            end else begin
                tick_en = (cyc % td == 0);
                bit_en  = (cyc % (16 * td) == 0);
                if (bit_en) begin
                    if (qrd < qwr) begin
                        bit_in = q[qrd];
                        qrd++;
                    end else begin
                        bit_in = 1'b1;
                    end
                end
            end
        end
    end

    // Output monitor: pass-through check or character decoding
    always @(negedge clk) begin
        int d, w;
        d = 16 * td;
        if (byp_chk) begin
            check(async_out === bit_in, fsk_mode ? "R7 bypass" : "R8 bypass", async_out, bit_in);
        end else if (mon_en && rst_n) begin
            case (ms)
                0: if (async_out == 1'b0) begin ms = 1; k = 0; rxv = '0; end
                1: begin
                    k++;
                    for (int j = 0; j < 11; j++)
                        if (j < nd_cur && k == d * (j + 1) + d / 2) rxv[j] = async_out;
                    if (k == d * (nd_cur + 1)) begin
                        check(async_out == 1'b1, "R3 stop level", async_out, 1);
                        ms = 2;
                    end
                end
                default: begin
                    k++;
                    w = k - d * (nd_cur + 1);
                    if (async_out == 1'b0) begin
                        finish_char(w);
                        ms = 1; k = 0; rxv = '0;
                    end else if (w > d) begin
                        finish_char(w);
                        ms = 0;
                    end
                end
            endcase
        end
    end

    // Send a burst; every dk-th character (dk > 0) has its stop deleted
    task automatic run_burst(int s, bit e, int n, int dk, string req);
        int guard;
        logic [15:0] dv;
        bit del;
        char_len = 2'(s);
        ext_ovs  = e;
        nd_cur   = ndata(s);
        ext_cur  = e;
        ecount = 0; ridx = 0; ms = 0;
        qwr = 0; qrd = 0;
        for (int i = 0; i < n; i++) begin
            dv  = 16'($urandom) & 16'((1 << nd_cur) - 1);
            del = (dk > 0) && ((i + 1) % dk == 0) && (i < n - 1);
            exp_data[ecount] = int'(dv);
            exp_del[ecount]  = del;
            ecount++;
            q[qwr] = 1'b0; qwr++;
            for (int j = 0; j < nd_cur; j++) begin q[qwr] = dv[j]; qwr++; end
            if (!del) begin q[qwr] = 1'b1; qwr++; end
        end
        guard = 0;
        while (ridx < n && guard < 20000) begin
            @(posedge clk);
            guard++;
        end
        check(ridx == n, req, ridx, n);
        repeat (40 * td) @(posedge clk);
    endtask

    initial begin
        void'($urandom(32'h5A17_0C3E));
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(async_out == 1'b1, "R1 reset mark", async_out, 1);
        @(posedge clk); #2;
        rst_n = 1'b1;
        mon_en = 1'b1;

        // R1: idle marks only, nothing comes out
        repeat (200) begin
            @(negedge clk);
            check(async_out == 1'b1, "R1 idle", async_out, 1);
        end

        // R2..R6: every length in both ranges at the highest deletion rate
        for (int s = 0; s < 4; s++) begin
            run_burst(s, 1'b0, 16, 8, "R2 R6 burst count");
            run_burst(s, 1'b1, 16, 4, "R2 R5 burst count");
        end
        // R10: a stop deleted on every character
        run_burst(3, 1'b1, 8, 1, "R10 burst count");
        run_burst(0, 1'b0, 8, 1, "R10 burst count");
        // R3: no deletion at all
        run_burst(2, 1'b0, 6, 0, "R3 burst count");
        // R11: one tick every other clock
        td = 2;
        run_burst(1, 1'b1, 10, 4, "R11 burst count");
        td = 1;
        repeat (40) @(posedge clk);

        // R9: abandon a partial character by switching to bypass
        char_len = 2'd0;
        ecount = 0; ridx = 0; qrd = 0; qwr = 0; ms = 0;
        q[0] = 1'b0; q[1] = 1'b1; q[2] = 1'b0; q[3] = 1'b1; qwr = 4;
        while (qrd < qwr) @(posedge clk);
        repeat (20) @(posedge clk);
        #2;
        mon_en = 0; sync_mode = 1'b1; byp_drive = 1; byp_chk = 1;
        repeat (150) @(posedge clk);
        #2;
        fsk_mode = 1'b1;   // R7 with sync flag also set
        repeat (150) @(posedge clk);
        #2;
        sync_mode = 1'b0;  // R7 alone
        repeat (150) @(posedge clk);
        #2;
        byp_chk = 0; byp_drive = 0; fsk_mode = 1'b0; sync_mode = 1'b0;
        bit_en = 1'b0; bit_in = 1'b1; tick_en = 1'b1;
        ms = 0; mon_en = 1;
        repeat (400) @(posedge clk);
        @(negedge clk);
        check(ridx == 0, "R9 no stale char", ridx, 0);
        check(async_out == 1'b1, "R9 mark after bypass", async_out, 1);

        // R4: a deleted stop right after bypass still decodes
        run_burst(1, 1'b1, 4, 2, "R4 after bypass count");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule